// File: doc/BRIEF.md
# GPIO Output Bank with Atomic Set and Clear

This block is a bank of up to 64 general-purpose pins that sits behind a plain 64-bit register bus. Software never writes the output data word directly. It sends a mask to a set port or to a clear port, and only the bits marked with a one change. Two agents can therefore each drive their own pins without a read-modify-write sequence. The input pins pass through a synchronizer and can be read back as one word. The stored output word can be read back too.

Every pin has its own configuration word. The word holds an output enable, a polarity flip, an open-drain selector and a function-select field. The block combines the stored output bit with that word to produce a pad data signal and a pad enable signal for each pin, ready for an external pad model. Any pin whose function select is nonzero belongs to some other function. The bank then leaves that pin undriven and flags the handover on a per-pin ownership output.

Top module: `gpio_setclr_bank`

## Requirements
- R1: A synchronous active-low reset clears the output word and every configuration word. While reset is low and in the first cycle after it, `pad_oe` and `pad_out` are all zero and `pin_is_gpio` is all ones.
- R2: A write to offset 0x008 sets each output bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to offset 0x010 clears each output bit whose write-data bit is 1. Bits written as 0 keep their value. If a set and a clear of the same bit ever coincide, the clear wins.
- R4: A read strobe returns its data on `bus_rdata` in the following cycle. `bus_rdata` is zero in any cycle that does not follow a read. Offset 0x008 reads back the output word, and offset 0x010 reads as zero. A read issued in the same cycle as a write returns the value from before the write.
- R5: Pin i has its configuration word at offset 0x400 + 8*i. In that word, bit 0 is output enable, bit 1 is polarity flip, bit 12 is open-drain, and bits 25:16 are function select. Readback returns exactly these fields, and every other bit reads as 0.
- R6: For a push-pull pin (bit 12 clear, function select zero), `pad_out` equals the output bit XOR the flip bit, and `pad_oe` equals the enable bit.
- R7: For an open-drain pin, `pad_out` is 0. `pad_oe` is high only when the enable bit is set and the output bit XOR the flip bit is 0.
- R8: For a pin whose function select is nonzero, `pin_is_gpio` is low and both `pad_oe` and `pad_out` are 0.
- R9: A read of offset 0x000 returns each pin's synchronized input XOR its flip bit. The synchronizer is SYNC_STAGES flops deep (default 2).
- R10: A read of offset 0x090 returns the pin count in bits 7:0 and the interrupt vector base in bits 15:8. All higher bits are zero.
- R11: Writes to offsets 0x000 and 0x090, to unmapped offsets and to offsets that are not 8-byte aligned leave all state unchanged. Reads of unmapped or unaligned offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after `bus_rd` |
| pad_in | input | 64 | Raw pin inputs (asynchronous) |
| pad_out | output | 64 | Per-pin pad data |
| pad_oe | output | 64 | Per-pin pad drive enable |
| pin_is_gpio | output | 64 | High where the pin is under this bank's control |

## Verification
The bus accepts a read and a write in the same cycle. The case that matters is a write to the set port while the output word is being read at that same port. The bench raises both strobes on one clock edge with a mask that changes a known bit. It then expects the returned word to hold the old contents. A second plain read must show the new bit, which proves that the write still landed and that the read path sampled the register before the update.

// File: rtl/gpio_bank_pkg.sv
// Package: shared offsets, field positions and the per-pin configuration type
// for the set/clear GPIO bank. Assumes a 64-bit data bus and byte offsets.
package gpio_bank_pkg;

    localparam int BUS_W = 64;

    // Register offsets (byte addresses, 8-byte aligned)
    localparam logic [11:0] OFS_RXDAT    = 12'h000;
    localparam logic [11:0] OFS_SET      = 12'h008;
    localparam logic [11:0] OFS_CLR      = 12'h010;
    localparam logic [11:0] OFS_CONST    = 12'h090;
    localparam logic [11:0] OFS_CFG_BASE = 12'h400;

    // Field positions inside a configuration word
    localparam int CFG_OE_BIT   = 0;
    localparam int CFG_INV_BIT  = 1;
    localparam int CFG_OD_BIT   = 12;
    localparam int CFG_FSEL_LO  = 16;
    localparam int CFG_FSEL_W   = 10;

    typedef struct packed {
        logic [CFG_FSEL_W-1:0] fsel;
        logic                  od;
        logic                  inv;
        logic                  oe;
    } pin_cfg_t;

    // Extract the stored fields from a bus word
    function automatic pin_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        pin_cfg_t c;
        c.oe   = w[CFG_OE_BIT];
        c.inv  = w[CFG_INV_BIT];
        c.od   = w[CFG_OD_BIT];
        c.fsel = w[CFG_FSEL_LO +: CFG_FSEL_W];
        return c;
    endfunction

    // Place the stored fields back at their bus positions, others zero
    function automatic logic [BUS_W-1:0] cfg_to_word(input pin_cfg_t c);
        logic [BUS_W-1:0] w;
        w                            = '0;
        w[CFG_OE_BIT]                = c.oe;
        w[CFG_INV_BIT]               = c.inv;
        w[CFG_OD_BIT]                = c.od;
        w[CFG_FSEL_LO +: CFG_FSEL_W] = c.fsel;
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-flop synchronizer for the raw pin inputs.
// Assumes: STAGES >= 1; each bit is treated independently (no bus coherency).
module gpio_in_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: capture the asynchronous pins
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            // Later flops: let metastability settle
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_store.sv
// Module: per-pin configuration storage with one write port and one read port.
// Assumes: wr_idx/rd_idx are only meaningful when the caller decoded a hit;
// out-of-range read indexes return zero.
module gpio_cfg_store
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BUS_W-1:0] wr_word,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BUS_W-1:0] rd_word,
    output logic [NPINS-1:0] oe_vec,
    output logic [NPINS-1:0] inv_vec,
    output logic [NPINS-1:0] od_vec,
    output logic [NPINS-1:0] own_vec
);
    pin_cfg_t cfg_q [NPINS];

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // Hold the configuration of pin p; update on an addressed write
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[p] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(p)))
                cfg_q[p] <= cfg_from_word(wr_word);
        end

        assign oe_vec[p]  = cfg_q[p].oe;
        assign inv_vec[p] = cfg_q[p].inv;
        assign od_vec[p]  = cfg_q[p].od;
        assign own_vec[p] = (cfg_q[p].fsel == '0);
    end

    // Read port: format the selected pin's fields as a bus word
    always_comb begin
        if (int'(rd_idx) < NPINS) rd_word = cfg_to_word(cfg_q[rd_idx]);
        else                      rd_word = '0;
    end

endmodule

// File: rtl/gpio_pad_drive.sv
// Module: per-pin pad driver. Combines the output bit with the pin's polarity,
// drive mode and ownership into pad data and pad enable.
// Assumes: all inputs are registered elsewhere; this stage is pure logic.
module gpio_pad_drive #(
    parameter int NPINS = 64
) (
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] oe,
    input  logic [NPINS-1:0] inv,
    input  logic [NPINS-1:0] od,
    input  logic [NPINS-1:0] own,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic eff;
        // Effective level after the polarity flip
        assign eff = latch[p] ^ inv[p];
        // Open-drain only pulls low; push-pull follows the enable bit
        always_comb begin
            if (!own[p]) begin
                pad_oe[p]  = 1'b0;
                pad_out[p] = 1'b0;
            end else if (od[p]) begin
                pad_oe[p]  = oe[p] & ~eff;
                pad_out[p] = 1'b0;
            end else begin
                pad_oe[p]  = oe[p];
                pad_out[p] = eff;
            end
        end
    end

endmodule

// File: rtl/gpio_setclr_bank.sv
// Module: GPIO bank top. Decodes the register bus, keeps the output word that
// changes only through set/clear masks, and drives per-pin pad signals.
// Assumes: NPINS <= 64; ADDR_W wide enough for OFS_CFG_BASE + 8*NPINS;
// reads return registered data one cycle after bus_rd.
module gpio_setclr_bank
    import gpio_bank_pkg::*;
#(
    parameter int          NPINS       = 64,
    parameter int          ADDR_W      = 12,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  VEC_BASE    = 8'd48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pin_is_gpio
);
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(OFS_CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(int'(OFS_CFG_BASE) + 8 * (NPINS - 1));
    localparam logic [BUS_W-1:0]  CONST_WORD = BUS_W'({VEC_BASE, 8'(NPINS)});

    logic              aligned;
    logic              hit_rx, hit_set, hit_clr, hit_const, hit_cfg;
    logic [ADDR_W-1:0] cfg_off;
    logic [IDX_W-1:0]  cfg_idx;
    logic [NPINS-1:0]  set_mask, clr_mask;
    logic [NPINS-1:0]  latch_q;
    logic [NPINS-1:0]  rx_sync;
    logic [NPINS-1:0]  oe_vec, inv_vec, od_vec, own_vec;
    logic [BUS_W-1:0]  cfg_rd_word;
    logic [BUS_W-1:0]  rd_next;

    // Address decode: aligned single-register hits and the config window
    always_comb begin
        aligned   = (bus_addr[2:0] == 3'b000);
        hit_rx    = aligned && (bus_addr == ADDR_W'(OFS_RXDAT));
        hit_set   = aligned && (bus_addr == ADDR_W'(OFS_SET));
        hit_clr   = aligned && (bus_addr == ADDR_W'(OFS_CLR));
        hit_const = aligned && (bus_addr == ADDR_W'(OFS_CONST));
        hit_cfg   = aligned && (bus_addr >= CFG_LO) && (bus_addr <= CFG_HI);
        cfg_off   = bus_addr - CFG_LO;
        cfg_idx   = cfg_off[IDX_W+2:3];
    end

    // Masks applied to the output word this cycle
    always_comb begin
        set_mask = (bus_wr && hit_set) ? bus_wdata[NPINS-1:0] : '0;
        clr_mask = (bus_wr && hit_clr) ? bus_wdata[NPINS-1:0] : '0;
    end

    // Output word: clear has priority over set for the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q | set_mask) & ~clr_mask;
    end

    gpio_in_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (rx_sync)
    );

    gpio_cfg_store #(
        .NPINS (NPINS),
        .IDX_W (IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && hit_cfg),
        .wr_idx  (cfg_idx),
        .wr_word (bus_wdata),
        .rd_idx  (cfg_idx),
        .rd_word (cfg_rd_word),
        .oe_vec  (oe_vec),
        .inv_vec (inv_vec),
        .od_vec  (od_vec),
        .own_vec (own_vec)
    );

    gpio_pad_drive #(
        .NPINS (NPINS)
    ) u_drive (
        .latch   (latch_q),
        .oe      (oe_vec),
        .inv     (inv_vec),
        .od      (od_vec),
        .own     (own_vec),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pin_is_gpio = own_vec;

    // Read mux: select the addressed register, zero when nothing matches
    always_comb begin
        rd_next = '0;
        if (hit_rx)         rd_next = BUS_W'(rx_sync ^ inv_vec);
        else if (hit_set)   rd_next = BUS_W'(latch_q);
        else if (hit_const) rd_next = CONST_WORD;
        else if (hit_cfg)   rd_next = cfg_rd_word;
    end

    // Registered read data; zero in cycles that do not follow a read
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/gpio_setclr_bank_chk.sv
// Module: assertion checker bound into gpio_setclr_bank. Observes the bus,
// the pad outputs and the output word.
module gpio_setclr_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int          NPINS    = 64,
    parameter int          ADDR_W   = 12,
    parameter logic [7:0]  VEC_BASE = 8'd48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pin_is_gpio,
    input logic [NPINS-1:0]  latch_q
);
    // R2: every bit written as 1 to the set port is high afterwards
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SET)) |=>
        ((latch_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R3: every bit written as 1 to the clear port is low afterwards
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) |=>
        ((latch_q & $past(bus_wdata[NPINS-1:0])) == '0));

    // R11: without a write the output word does not move
    p_hold_no_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(latch_q));

    // R4: read data is zero in cycles that do not follow a read
    p_rdata_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R10: the constants word returns pin count and vector base
    p_const_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_CONST)) |=>
        (bus_rdata == BUS_W'({VEC_BASE, 8'(NPINS)})));

    // R8: a pin handed to another function is never driven
    p_foreign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out) & ~pin_is_gpio) == '0);

endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(
    .NPINS    (NPINS),
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pin_is_gpio (pin_is_gpio),
    .latch_q     (latch_q)
);

// File: tb/gpio_setclr_bank_bench.sv
`timescale 1ns/1ps
module gpio_setclr_bank_bench;

    localparam int OP_WR   = 0;
    localparam int OP_RD   = 1;
    localparam int OP_OUT  = 2;
    localparam int OP_OE   = 3;
    localparam int OP_GPIO = 4;

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 33;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 12'h008, 64'hF0F0, 64'h0, 4'd2},                 // R2 set
        '{3'd1, 12'h008, 64'h0, 64'hF0F0, 4'd2},                 // R2
        '{3'd0, 12'h008, 64'h0F00, 64'h0, 4'd2},                 // R2 zeros keep
        '{3'd1, 12'h008, 64'h0, 64'hFFF0, 4'd2},                 // R2
        '{3'd0, 12'h010, 64'h00F0, 64'h0, 4'd3},                 // R3 clear
        '{3'd1, 12'h008, 64'h0, 64'hFF00, 4'd3},                 // R3
        '{3'd1, 12'h010, 64'h0, 64'h0, 4'd4},                    // R4 clear port reads 0
        '{3'd0, 12'h400, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd5},  // R5 all ones
        '{3'd1, 12'h400, 64'h0, 64'h03FF_1003, 4'd5},            // R5 fields only
        '{3'd0, 12'h400, 64'h1, 64'h0, 4'd5},                    // R5 pin0 enable
        '{3'd1, 12'h400, 64'h0, 64'h1, 4'd5},                    // R5
        '{3'd2, 12'h000, 64'h0, 64'hFF00, 4'd6},                 // R6 push-pull data
        '{3'd3, 12'h000, 64'h0, 64'h1, 4'd6},                    // R6 enable
        '{3'd0, 12'h440, 64'h3, 64'h0, 4'd6},                    // R6 pin8 enable+flip
        '{3'd2, 12'h000, 64'h0, 64'hFE00, 4'd6},                 // R6 flipped
        '{3'd3, 12'h000, 64'h0, 64'h101, 4'd6},                  // R6
        '{3'd0, 12'h448, 64'h1001, 64'h0, 4'd7},                 // R7 pin9 open-drain
        '{3'd2, 12'h000, 64'h0, 64'hFC00, 4'd7},                 // R7 data 0
        '{3'd3, 12'h000, 64'h0, 64'h101, 4'd7},                  // R7 released
        '{3'd0, 12'h010, 64'h200, 64'h0, 4'd7},                  // R7 drive low
        '{3'd2, 12'h000, 64'h0, 64'hFC00, 4'd7},                 // R7
        '{3'd3, 12'h000, 64'h0, 64'h301, 4'd7},                  // R7 pulls
        '{3'd0, 12'h440, 64'h10001, 64'h0, 4'd8},                // R8 pin8 foreign
        '{3'd4, 12'h000, 64'h0, 64'hFFFF_FFFF_FFFF_FEFF, 4'd8},  // R8 ownership
        '{3'd3, 12'h000, 64'h0, 64'h201, 4'd8},                  // R8 no enable
        '{3'd2, 12'h000, 64'h0, 64'hFC00, 4'd8},                 // R8 data forced 0
        '{3'd1, 12'h090, 64'h0, 64'h3040, 4'd10},                // R10 constants
        '{3'd0, 12'h090, 64'hFFFF, 64'h0, 4'd11},                // R11 write ignored
        '{3'd1, 12'h090, 64'h0, 64'h3040, 4'd11},                // R11
        '{3'd1, 12'h404, 64'h0, 64'h0, 4'd11},                   // R11 unaligned
        '{3'd1, 12'h800, 64'h0, 64'h0, 4'd11},                   // R11 unmapped
        '{3'd0, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd11}, // R11 input word
        '{3'd1, 12'h008, 64'h0, 64'hFD00, 4'd11}                 // R11 unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_out, pad_oe, pin_is_gpio;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_setclr_bank u_gpio_setclr_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pin_is_gpio (pin_is_gpio)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [63:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [63:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] rd;
        string tag;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", pad_oe, 64'h0);
        check("R1", pin_is_gpio, {64{1'b1}});
        rst_n = 1'b1;
        check("R1", pad_out, 64'h0);
        bus_read(12'h008, rd); check("R1", rd, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            tag = $sformatf("R%0d", VECS[i].req);
            case (int'(VECS[i].op))
                OP_WR:   bus_write(VECS[i].addr, VECS[i].data);
                OP_RD:   begin bus_read(VECS[i].addr, rd); check(tag, rd, VECS[i].exp); end
                OP_OUT:  check(tag, pad_out, VECS[i].exp);
                OP_OE:   check(tag, pad_oe, VECS[i].exp);
                default: check(tag, pin_is_gpio, VECS[i].exp);
            endcase
        end

        // R9: input word with pin10 flipped, after the synchronizer
        bus_write(12'h450, 64'h2);
        pad_in = 64'hA5;
        repeat (3) @(negedge clk);
        bus_read(12'h000, rd); check("R9", rd, 64'h4A5);

        // R4: read and write of the set port in the same cycle
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h008; bus_wdata = 64'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R4", bus_rdata, 64'hFD00);
        @(negedge clk);
        check("R4", bus_rdata, 64'h0);
        bus_read(12'h008, rd); check("R4", rd, 64'hFD01);

        // R1: reset in mid-run wipes output word and configuration
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", pad_oe, 64'h0);
        rst_n = 1'b1;
        check("R1", pin_is_gpio, {64{1'b1}});
        bus_read(12'h008, rd); check("R1", rd, 64'h0);
        bus_read(12'h440, rd); check("R1", rd, 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule